// File: doc/BRIEF.md
# Expansion Bus Segment Controller

This block sits between an internal bus master and external memory or expansion devices. It takes one access request at a time and decodes the top address nibble into one of six external segments of 256 MB each. It also recognises a seventh segment that maps 2 KB of on-chip SRAM. For an external segment it drives a chip select and an SRAM-like read or write strobe. The strobes are held for the number of wait states set in that segment's configuration word, and the cycle is stretched further while the external ready input is low once those wait states have run out.

Each segment has its own configuration word. The word sets the bus width, a page/burst enable, a wait count for nonsequential accesses and a wait count for sequential accesses. An access is sequential when it follows the previous one back to back, in the same segment, at the next address for that width. A run of sequential accesses is broken after four beats, so the bus goes idle for one cycle and other masters can get in. Two chip selects can each be given over to a slot-controller interface by their own enable bit.

Top module: `expbus_ctrl`

## Requirements
- R1: After reset, and while no access is in progress, all chip selects, both slot selects, `sram_sel`, `oe_n`, `we_n` and `req_done` are inactive, and `req_ready` is high.
- R2: A request with `req_addr[31:28]` equal to i, for i from 0 to 5, drives `cs_n[i]` low for the whole access. At most one of the chip selects, slot selects and `sram_sel` is active at any time.
- R3: Address code 6 hits the on-chip SRAM only when `req_addr[27:11]` is zero. A hit asserts `sram_sel` with zero wait states, ignores `ext_ready` and drives no strobe. A code-6 address with any of bits 27:11 set selects nothing, so the SRAM never aliases.
- R4: Codes 7 to 15 select nothing and complete with zero wait states.
- R5: Segment i's configuration word is `cfg_flat[7*i+6 : 7*i]`. Bits 1:0 are the width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), bit 2 is the page enable, bits 4:3 are the nonsequential field and bits 6:5 are the sequential field. `bus_width` shows the width field during the access.
- R6: A nonsequential access to an external segment takes its nonsequential field plus one wait states (1 to 4). `req_done` is high in the cycle that follows that many cycles after acceptance.
- R7: A sequential access takes its sequential field as wait states (0 to 3). A sequential write with a field of 0 takes 1.
- R8: An access is sequential (`bus_seq` high) only when all of these hold: it is accepted in the cycle in which the previous access completes; it is in the same external segment; its address is the previous address plus 1, 2 or 4 bytes for width 8, 16 or 32; and the page enable is set.
- R9: While `ext_ready` is low after the programmed wait states have run out, the access does not complete. While it is low during the wait states, it has no effect.
- R10: After four chained accesses of one sequential run, `req_ready` is low in the cycle the fourth completes. The next access is accepted only after one idle cycle and is nonsequential.
- R11: `slot_en[0]` moves segment 4's select from `cs_n[4]` to `slot_sel[0]`, and `slot_en[1]` moves segment 5's select from `cs_n[5]` to `slot_sel[1]`. Each bit acts on its own segment only.
- R12: Reads to an external segment or slot drive `oe_n` low and writes drive `we_n` low. The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Request is accepted at this clock edge when `req_valid` is high |
| req_done | output | 1 | Current access completes at this clock edge |
| cfg_flat | input | 42 | Six 7-bit segment configuration words |
| slot_en | input | 2 | Hands segment 4 / segment 5 to the slot-controller select |
| ext_ready | input | 1 | External ready; low stretches the cycle after the wait states |
| bus_addr | output | 32 | Address of the access in progress |
| bus_width | output | 2 | Width field of the segment being accessed |
| bus_seq | output | 1 | Access in progress is sequential |
| cs_n | output | 6 | Active-low external segment selects |
| slot_sel | output | 2 | Active-high slot-controller selects |
| sram_sel | output | 1 | On-chip SRAM selected |
| oe_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |

## Verification
The hardest state to reach is the fifth beat of a chained sequential run. The master has to present each next consecutive address in exactly the cycle in which the previous beat completes. The bench does this by issuing the next request in the same half cycle in which it sees `req_done`, and it counts the cycles in which `req_ready` stays low before acceptance. The same back-to-back issue is used to show that a write run with a zero sequential field still gets one wait state. Ready stretching is driven by holding `ext_ready` low for a chosen number of cycles after acceptance, both shorter and longer than the programmed wait.

// File: rtl/expbus_pkg.sv
// Shared types for the expansion bus controller.
// Assumes a 7-bit segment configuration word laid out as seg_cfg_t.
package expbus_pkg;
    localparam int CFG_W = 7;

    typedef struct packed {
        logic [1:0] seq_ws;   // sequential wait field
        logic [1:0] nseq_ws;  // nonsequential wait field (value+1 waits)
        logic       page_en;  // allow sequential accesses
        logic [1:0] width;    // 0: 8-bit, 1: 16-bit, 2/3: 32-bit
    } seg_cfg_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_EXT  = 2'd1,
        TGT_SRAM = 2'd2
    } tgt_e;

    // Address step between consecutive beats for a width code.
    function automatic logic [2:0] beat_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/expbus_decode.sv
// Address decoder: maps the top address bits to an external segment,
// the fully decoded on-chip SRAM window, or nothing.
// Assumes the external segments occupy the lowest codes.
module expbus_decode
    import expbus_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEG_LSB  = 28,
    parameter int NSEG     = 6,
    parameter int SRAM_SEG = 6,
    parameter int SRAM_AW  = 11,
    localparam int SEG_W   = ADDR_W - SEG_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [SEG_W-1:0]  seg
);
    localparam logic [SEG_W-1:0] NSEG_V = SEG_W'(NSEG);
    localparam logic [SEG_W-1:0] SRAM_V = SEG_W'(SRAM_SEG);

    assign seg = addr[ADDR_W-1:SEG_LSB];

    // Classify the target; SRAM hits only when all bits above its window are zero.
    always_comb begin
        if (seg < NSEG_V)
            tgt = TGT_EXT;
        else if (seg == SRAM_V && addr[SEG_LSB-1:SRAM_AW] == '0)
            tgt = TGT_SRAM;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/expbus_seqdet.sv
// Sequential-access detector and run limiter.
// Assumes 'accept' pulses once per accepted request and 'chained' is high
// when that request follows the previous one with no idle cycle.
module expbus_seqdet
    import expbus_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEG_W   = 4,
    parameter int MAX_RUN = 4,
    localparam int RUN_W  = $clog2(MAX_RUN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              chained,
    input  tgt_e              tgt,
    input  logic [SEG_W-1:0]  seg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              page_en,
    input  logic [1:0]        width,
    output logic              is_seq,
    output logic              run_full
);
    logic [ADDR_W-1:0] prev_addr;
    logic [SEG_W-1:0]  prev_seg;
    logic              prev_ext;
    logic [RUN_W-1:0]  run_cnt;
    logic [ADDR_W-1:0] next_addr;

    assign next_addr = prev_addr + ADDR_W'(beat_bytes(width));
    assign run_full  = (run_cnt == RUN_W'(MAX_RUN));

    // Sequential only for a chained hit on the next address of the same page-enabled segment.
    always_comb begin
        is_seq = chained && (tgt == TGT_EXT) && prev_ext && (seg == prev_seg)
                 && page_en && (addr == next_addr);
    end

    // Remember the last accepted access and count the beats of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            prev_seg  <= '0;
            prev_ext  <= 1'b0;
            run_cnt   <= '0;
        end else if (accept) begin
            prev_addr <= addr;
            prev_seg  <= seg;
            prev_ext  <= (tgt == TGT_EXT);
            run_cnt   <= is_seq ? run_cnt + 1'b1 : RUN_W'(1);
        end
    end
endmodule

// File: rtl/expbus_waitgen.sv
// Bus cycle timer: holds an access for the loaded number of wait states,
// then waits for ready when the target uses it.
// Assumes 'start' has priority over completion of the previous access.
module expbus_waitgen #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    input  logic             use_rdy_in,
    input  logic             ext_ready,
    output logic             active,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic             use_rdy;

    assign done = active && (cnt == '0) && (!use_rdy || ext_ready);

    // Load on start, count wait states down, drop active on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            use_rdy <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            cnt     <= load;
            use_rdy <= use_rdy_in;
        end else if (done) begin
            active  <= 1'b0;
        end else if (active && cnt != '0) begin
            cnt     <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/expbus_ctrl.sv
// Expansion bus segment controller top: decodes requests, picks wait counts
// from per-segment configuration, drives selects and strobes, and limits runs.
// Assumes cfg_flat and slot_en are held steady while accesses are in flight.
module expbus_ctrl
    import expbus_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_LSB   = 28,
    parameter int NSEG      = 6,
    parameter int SRAM_SEG  = 6,
    parameter int SRAM_AW   = 11,
    parameter int SLOT_BASE = 4,
    parameter int NSLOT     = 2,
    parameter int MAX_RUN   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  req_ready,
    output logic                  req_done,
    input  logic [NSEG*CFG_W-1:0] cfg_flat,
    input  logic [NSLOT-1:0]      slot_en,
    input  logic                  ext_ready,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [1:0]            bus_width,
    output logic                  bus_seq,
    output logic [NSEG-1:0]       cs_n,
    output logic [NSLOT-1:0]      slot_sel,
    output logic                  sram_sel,
    output logic                  oe_n,
    output logic                  we_n
);
    localparam int SEG_W = ADDR_W - SEG_LSB;
    localparam int CNT_W = 3;

    tgt_e             dec_tgt, cur_tgt;
    logic [SEG_W-1:0] dec_seg, cur_seg;
    seg_cfg_t         cfg_arr [NSEG];
    seg_cfg_t         cfg_sel;
    logic             active, done, accept, chained, is_seq, run_full;
    logic [CNT_W-1:0] wait_val;
    logic             cur_write, cur_seq, start_ext_wr;
    logic [1:0]       cur_width;
    logic [ADDR_W-1:0] cur_addr;

    expbus_decode #(
        .ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB), .NSEG(NSEG),
        .SRAM_SEG(SRAM_SEG), .SRAM_AW(SRAM_AW)
    ) u_dec (
        .addr(req_addr), .tgt(dec_tgt), .seg(dec_seg)
    );

    // Unpack one configuration word per external segment.
    for (genvar g = 0; g < NSEG; g++) begin : g_cfg
        assign cfg_arr[g] = seg_cfg_t'(cfg_flat[g*CFG_W +: CFG_W]);
    end

    // Select the configuration of the addressed segment.
    always_comb begin
        cfg_sel = '0;
        for (int i = 0; i < NSEG; i++)
            if (dec_tgt == TGT_EXT && dec_seg == SEG_W'(i))
                cfg_sel = cfg_arr[i];
    end

    assign req_ready    = !active || (done && !run_full);
    assign accept       = req_valid && req_ready;
    assign chained      = active && done;
    assign req_done     = done;
    assign start_ext_wr = accept && req_write && (dec_tgt == TGT_EXT);

    expbus_seqdet #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .MAX_RUN(MAX_RUN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .chained(chained),
        .tgt(dec_tgt), .seg(dec_seg), .addr(req_addr),
        .page_en(cfg_sel.page_en), .width(cfg_sel.width),
        .is_seq(is_seq), .run_full(run_full)
    );

    // Wait count: none for internal targets, field+1 nonsequential, field sequential (writes at least 1).
    always_comb begin
        if (dec_tgt != TGT_EXT)
            wait_val = '0;
        else if (is_seq)
            wait_val = (req_write && cfg_sel.seq_ws == 2'd0) ? CNT_W'(1) : CNT_W'(cfg_sel.seq_ws);
        else
            wait_val = CNT_W'(cfg_sel.nseq_ws) + CNT_W'(1);
    end

    expbus_waitgen #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .start(accept), .load(wait_val),
        .use_rdy_in(dec_tgt == TGT_EXT), .ext_ready(ext_ready),
        .active(active), .done(done)
    );

    // Capture the attributes of the accepted access for the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tgt   <= TGT_NONE;
            cur_seg   <= '0;
            cur_write <= 1'b0;
            cur_seq   <= 1'b0;
            cur_width <= '0;
            cur_addr  <= '0;
        end else if (accept) begin
            cur_tgt   <= dec_tgt;
            cur_seg   <= dec_seg;
            cur_write <= req_write;
            cur_seq   <= is_seq;
            cur_width <= cfg_sel.width;
            cur_addr  <= req_addr;
        end
    end

    assign bus_addr  = cur_addr;
    assign bus_width = cur_width;
    assign bus_seq   = active && cur_seq;
    assign sram_sel  = active && (cur_tgt == TGT_SRAM);
    assign oe_n      = !(active && cur_tgt == TGT_EXT && !cur_write);
    assign we_n      = !(active && cur_tgt == TGT_EXT && cur_write);

    // Chip selects, with the slot-capable segments released when their slot is enabled.
    for (genvar g = 0; g < NSEG; g++) begin : g_cs
        logic hit;
        assign hit = active && (cur_tgt == TGT_EXT) && (cur_seg == SEG_W'(g));
        if (g >= SLOT_BASE && g < SLOT_BASE + NSLOT) begin : g_slot
            assign cs_n[g] = !(hit && !slot_en[g-SLOT_BASE]);
        end else begin : g_plain
            assign cs_n[g] = !hit;
        end
    end

    // Slot-controller selects, each driven by its own enable.
    for (genvar j = 0; j < NSLOT; j++) begin : g_ss
        assign slot_sel[j] = active && (cur_tgt == TGT_EXT)
                             && (cur_seg == SEG_W'(SLOT_BASE + j)) && slot_en[j];
    end
endmodule

// File: rtl/expbus_ctrl_chk.sv
// Property checker for expbus_ctrl, attached by bind.
// Assumes the synchronous active-low reset of the controller.
module expbus_ctrl_chk #(
    parameter int NSEG      = 6,
    parameter int NSLOT     = 2,
    parameter int SLOT_BASE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_done,
    input logic             ext_ready,
    input logic [NSEG-1:0]  cs_n,
    input logic [NSLOT-1:0] slot_sel,
    input logic [NSLOT-1:0] slot_en,
    input logic             sram_sel,
    input logic             oe_n,
    input logic             we_n,
    input logic             run_full,
    input logic             start_ext_wr
);
    // R2: never more than one select active
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~cs_n, slot_sel, sram_sel}));

    // R12: read and write strobes exclusive
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R9: an external access completes only with ready high
    a_r9_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && (!oe_n || !we_n)) |-> ext_ready);

    // R7: an external write never completes in its first cycle
    a_r7_write_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
        start_ext_wr |=> !req_done);

    // R10: a full run is followed by an idle bus
    a_r10_run_break: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && run_full) |=> (&cs_n && slot_sel == '0 && !sram_sel));

    // R11: an enabled slot releases its chip select
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot_chk
        a_r11_slot_release: assert property (@(posedge clk) disable iff (!rst_n)
            slot_en[j] |-> cs_n[SLOT_BASE + j]);
    end
endmodule

bind expbus_ctrl expbus_ctrl_chk #(
    .NSEG(NSEG), .NSLOT(NSLOT), .SLOT_BASE(SLOT_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_done(req_done), .ext_ready(ext_ready),
    .cs_n(cs_n), .slot_sel(slot_sel), .slot_en(slot_en), .sram_sel(sram_sel),
    .oe_n(oe_n), .we_n(we_n), .run_full(run_full), .start_ext_wr(start_ext_wr)
);

// File: tb/expbus_ctrl_test.sv
// Directed bench for expbus_ctrl: one task per scenario.
module expbus_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, req_done;
    logic [41:0] cfg_flat = '0;
    logic [1:0]  slot_en = 2'b00;
    logic        ext_ready = 1'b1;
    logic [31:0] bus_addr;
    logic [1:0]  bus_width;
    logic        bus_seq;
    logic [5:0]  cs_n;
    logic [1:0]  slot_sel;
    logic        sram_sel, oe_n, we_n;

    int checks = 0, failures = 0;
    int r_gap, r_waits;
    logic [5:0] r_csn;
    logic [1:0] r_slot, r_width;
    logic r_sram, r_oe, r_we, r_seq;
    logic [31:0] r_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    expbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .req_done(req_done),
        .cfg_flat(cfg_flat), .slot_en(slot_en), .ext_ready(ext_ready),
        .bus_addr(bus_addr), .bus_width(bus_width), .bus_seq(bus_seq),
        .cs_n(cs_n), .slot_sel(slot_sel), .sram_sel(sram_sel),
        .oe_n(oe_n), .we_n(we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] mk(input logic [1:0] w, input logic pg,
                                      input logic [1:0] nsq, input logic [1:0] sq);
        return {sq, nsq, pg, w};
    endfunction

    task automatic set_cfg(input int seg, input logic [6:0] v);
        cfg_flat[seg*7 +: 7] = v;
    endtask

    // Present a request; ready is held low for 'hold' cycles after acceptance.
    // Returns at the half cycle where req_done is seen, with req_valid still high.
    task automatic issue(input logic [31:0] a, input logic wr, input int hold);
        int k;
        req_addr = a; req_write = wr; req_valid = 1'b1; ext_ready = 1'b1; r_gap = 0;
        #1;
        while (!req_ready) begin @(negedge clk); r_gap++; #1; end
        @(negedge clk);
        k = 0;
        ext_ready = (k >= hold);
        #1;
        r_csn = cs_n; r_slot = slot_sel; r_sram = sram_sel; r_oe = oe_n;
        r_we = we_n; r_seq = bus_seq; r_width = bus_width; r_addr = bus_addr;
        while (!req_done) begin
            @(negedge clk); k++; ext_ready = (k >= hold); #1;
        end
        r_waits = k;
        ext_ready = 1'b1;
    endtask

    task automatic release_bus();
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 cs_n", 32'(cs_n), 32'h3F);
        chk("R1 strobes", {30'd0, oe_n, we_n}, 32'h3);
        chk("R1 done", 32'(req_done), 0);
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 selects", {29'd0, slot_sel, sram_sel}, 0);
    endtask

    task automatic t_decode();
        for (int s = 0; s < 6; s++) begin
            issue({4'(s), 28'h0000100}, 1'b0, 0);
            release_bus();
            chk("R2 cs_n", 32'(r_csn), 32'(6'h3F & ~(6'd1 << s)));
            chk("R12 oe read", 32'(r_oe), 0);
            chk("R12 we read", 32'(r_we), 1);
            chk("R6 nseq waits", r_waits, 32'(s % 4 + 1));
            chk("R2 bus_addr", r_addr, {4'(s), 28'h0000100});
        end
        #1;
        chk("R1 idle after access", 32'(cs_n), 32'h3F);
    endtask

    task automatic t_sram_unmapped();
        issue(32'h6000_07FC, 1'b0, 3);
        release_bus();
        chk("R3 sram_sel", 32'(r_sram), 1);
        chk("R3 zero waits ignore ready", r_waits, 0);
        chk("R3 no strobe", {30'd0, r_oe, r_we}, 32'h3);
        chk("R3 no cs", 32'(r_csn), 32'h3F);
        issue(32'h6000_0800, 1'b1, 0);
        release_bus();
        chk("R3 no alias", {30'd0, r_sram, r_we}, 32'h1);
        issue(32'h7000_0000, 1'b0, 2);
        release_bus();
        chk("R4 code7 no select", {25'd0, r_csn, r_sram}, 32'h7E);
        chk("R4 code7 waits", r_waits, 0);
        issue(32'hF123_4560, 1'b1, 0);
        release_bus();
        chk("R4 code15 no strobe", {24'd0, r_csn, r_oe, r_we}, 32'hFF);
    endtask

    task automatic t_burst();
        set_cfg(1, mk(2'd2, 1'b1, 2'd2, 2'd0));
        issue(32'h1000_0100, 1'b0, 0);
        chk("R8 first beat nonseq", 32'(r_seq), 0);
        chk("R6 first beat waits", r_waits, 3);
        for (int b = 1; b < 4; b++) begin
            issue(32'h1000_0100 + 32'(4*b), 1'b0, 0);
            chk("R8 chained beat seq", 32'(r_seq), 1);
            chk("R7 seq zero waits", r_waits, 0);
            chk("R8 no gap", r_gap, 0);
        end
        issue(32'h1000_0110, 1'b0, 0);
        chk("R10 idle gap", r_gap, 1);
        chk("R10 fifth nonseq", 32'(r_seq), 0);
        chk("R10 fifth waits", r_waits, 3);
        issue(32'h1000_0114, 1'b0, 0);
        chk("R10 new run seq", 32'(r_seq), 1);
        release_bus();
        issue(32'h1000_0118, 1'b0, 0);
        release_bus();
        chk("R8 after idle nonseq", 32'(r_seq), 0);
    endtask

    task automatic t_write_seq();
        set_cfg(2, mk(2'd2, 1'b1, 2'd0, 2'd0));
        issue(32'h2000_0000, 1'b1, 0);
        chk("R6 write nseq waits", r_waits, 1);
        chk("R12 we write", {30'd0, r_oe, r_we}, 32'h2);
        issue(32'h2000_0004, 1'b1, 0);
        chk("R7 write seq min one", r_waits, 1);
        chk("R7 write is seq", 32'(r_seq), 1);
        release_bus();
        set_cfg(2, mk(2'd2, 1'b1, 2'd0, 2'd3));
        issue(32'h2000_0040, 1'b1, 0);
        issue(32'h2000_0044, 1'b1, 0);
        release_bus();
        chk("R7 write seq field3", r_waits, 3);
    endtask

    task automatic t_width_page();
        set_cfg(3, mk(2'd1, 1'b1, 2'd1, 2'd2));
        issue(32'h3000_0000, 1'b0, 0);
        chk("R5 width16", 32'(r_width), 1);
        issue(32'h3000_0002, 1'b0, 0);
        chk("R8 16-bit step seq", 32'(r_seq), 1);
        chk("R7 seq field2", r_waits, 2);
        issue(32'h3000_0006, 1'b0, 0);
        chk("R8 skipped addr nonseq", 32'(r_seq), 0);
        chk("R6 nseq field1", r_waits, 2);
        issue(32'h0000_0008, 1'b0, 0);
        chk("R8 other segment nonseq", 32'(r_seq), 0);
        release_bus();
        set_cfg(0, mk(2'd0, 1'b0, 2'd0, 2'd0));
        issue(32'h0000_0010, 1'b0, 0);
        issue(32'h0000_0011, 1'b0, 0);
        release_bus();
        chk("R8 page off nonseq", 32'(r_seq), 0);
        chk("R5 width8", 32'(r_width), 0);
    endtask

    task automatic t_ready();
        set_cfg(0, mk(2'd2, 1'b0, 2'd1, 2'd0));
        issue(32'h0000_0200, 1'b0, 5);
        release_bus();
        chk("R9 stretched", r_waits, 5);
        issue(32'h0000_0200, 1'b0, 2);
        release_bus();
        chk("R9 low during waits ignored", r_waits, 2);
        issue(32'h0000_0200, 1'b1, 1);
        release_bus();
        chk("R9 short low ignored", r_waits, 2);
    endtask

    task automatic t_slot();
        slot_en = 2'b01;
        issue(32'h4000_0000, 1'b0, 0);
        release_bus();
        chk("R11 seg4 slot", {24'd0, r_csn, r_slot}, {24'd0, 6'h3F, 2'b01});
        chk("R11 slot strobe", 32'(r_oe), 0);
        issue(32'h5000_0000, 1'b0, 0);
        release_bus();
        chk("R11 seg5 cs kept", {24'd0, r_csn, r_slot}, {24'd0, 6'h1F, 2'b00});
        slot_en = 2'b10;
        issue(32'h4000_0000, 1'b1, 0);
        release_bus();
        chk("R11 seg4 cs kept", {24'd0, r_csn, r_slot}, {24'd0, 6'h2F, 2'b00});
        issue(32'h5000_0000, 1'b1, 0);
        release_bus();
        chk("R11 seg5 slot", {24'd0, r_csn, r_slot}, {24'd0, 6'h3F, 2'b10});
        slot_en = 2'b00;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int s = 0; s < 6; s++) set_cfg(s, mk(2'd2, 1'b1, 2'(s % 4), 2'd0));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_sram_unmapped();
        t_burst();
        t_write_seq();
        t_width_page();
        t_ready();
        t_slot();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule